// File: doc/BRIEF.md
# Power-Good Reset Supervisor

This block is the digital core of a reset supervisor for one regulated rail. It drives a power-good level that downstream logic can use as an active-low reset. Comparator results, the enable pin, thermal and VCC status flags and soft-start status arrive as synchronous single-bit inputs. Each fault has its own entry flag and its own exit flag, so the hysteresis sits between two separate thresholds. The undervoltage and overvoltage faults also pass through deglitch filters that count cycles.

Power-good is released only after every fault has cleared and a programmable reset-active delay has then run to the end. Any fault that appears while the delay is counting aborts it, and the delay restarts in full once the faults are gone. The soft-start lockout is separate: it holds power-good low until the output reaches its target or a timeout expires, whichever comes first. Its release does not rerun the reset-active delay. A qualified overvoltage fault also raises a switch shutdown request and a switch-node pulldown enable.

Top module: `pg_supervisor`

## Requirements
- R1: The undervoltage fault sets, and power-good drops, on the clock edge that samples `uv_below` high for the FILT_CYC-th consecutive time. A shorter run does not set it.
- R2: The undervoltage fault clears only after `uv_above_hys` has been sampled high for FILT_CYC consecutive edges. While the fault is clear, `uv_above_hys` is ignored.
- R3: The overvoltage fault sets after `ov_above` has been high for FILT_CYC consecutive edges. It clears after `ov_below_hys` has been high for FILT_CYC consecutive edges. `ov_shutdown` and `sw_pulldown` are both 1 exactly while the fault is set.
- R4: Once the last fault clears, power-good rises exactly RST_CYC edges later, provided the soft-start lockout is released.
- R5: `en` low sets the enable fault on the next edge, and power-good is low from then on. After `en` returns high, the fault clears once `en` has been sampled high on EN_CYC consecutive edges.
- R6: An edge that samples `tsd_set` high sets the thermal fault. It clears only on an edge that samples `tsd_clr` high while `tsd_set` is low.
- R7: An edge that samples `vcc_low` high sets the VCC fault. It clears only on an edge that samples `vcc_high` high while `vcc_low` is low.
- R8: An edge that samples `ss_start` high arms the soft-start lockout and holds power-good low. The lockout releases on the first edge that samples `ss_done` high, or SS_CYC edges after the arming edge, whichever comes first. Its release raises power-good at once, with no reset-active delay.
- R9: A fault that appears while the reset-active delay is counting restarts that delay from zero once the fault clears.
- R10: A filter run that is cut short before it reaches FILT_CYC returns its count to zero. A later run must then last the full FILT_CYC edges.
- R11: While `rst` is high, `pg`, `ov_shutdown` and `sw_pulldown` are 0. Reset arms the soft-start lockout, starts its timeout and sets the enable fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable, high to run |
| uv_below | input | 1 | Output below undervoltage threshold |
| uv_above_hys | input | 1 | Output above undervoltage threshold plus hysteresis |
| ov_above | input | 1 | Output above overvoltage threshold |
| ov_below_hys | input | 1 | Output below overvoltage threshold minus hysteresis |
| tsd_set | input | 1 | Junction temperature above rising trip |
| tsd_clr | input | 1 | Junction temperature below falling trip |
| vcc_low | input | 1 | VCC below UVLO minus hysteresis |
| vcc_high | input | 1 | VCC above UVLO |
| ss_start | input | 1 | Soft-start initiation pulse |
| ss_done | input | 1 | Output has reached its target |
| pg | output | 1 | Power-good, low signals reset |
| ov_shutdown | output | 1 | Switch shutdown request on overvoltage |
| sw_pulldown | output | 1 | Switch-node pulldown enable |

## Verification
Every result appears a fixed number of edges after its stimulus. A filtered fault appears after FILT_CYC edges. The thermal and VCC faults, and a rise of `ss_start`, show on the next edge. Power-good returns RST_CYC edges after the clearing edge. It returns EN_CYC plus RST_CYC edges after `en` rises, and SS_CYC plus one edges after an unanswered `ss_start`. The bench drives inputs and samples outputs on falling edges, so after N rising edges it looks at a settled result. For each delay it checks the value one edge early and the value on the due edge. The glitch lengths are swept from 1 to FILT_CYC, both when entering and when leaving a fault.

// File: rtl/pg_supervisor.sv
module pg_supervisor #(
  parameter int FILT_CYC = 16,
  parameter int EN_CYC   = 64,
  parameter int RST_CYC  = 1024,
  parameter int SS_CYC   = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uv_below,
  input  logic uv_above_hys,
  input  logic ov_above,
  input  logic ov_below_hys,
  input  logic tsd_set,
  input  logic tsd_clr,
  input  logic vcc_low,
  input  logic vcc_high,
  input  logic ss_start,
  input  logic ss_done,
  output logic pg,
  output logic ov_shutdown,
  output logic sw_pulldown
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int EW = $clog2(EN_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int SW = $clog2(SS_CYC + 1);

  logic [1:0] flt;
  logic [1:0] enter_f, leave_f;
  logic       en_flt, tsd_flt, vcc_flt, any_flt;
  logic       rel, ss_lock;
  logic [EW-1:0] en_cnt;
  logic [RW-1:0] rel_cnt;
  logic [SW-1:0] ss_cnt;

  assign enter_f = {ov_above, uv_below};
  assign leave_f = {ov_below_hys, uv_above_hys};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic [FW-1:0] cnt;
    logic          q;
    assign q = flt[i] ? leave_f[i] : enter_f[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        flt[i] <= 1'b0;
        cnt    <= '0;
      end else if (!q) begin
        cnt <= '0;
      end else if (cnt == FW'(FILT_CYC - 1)) begin
        flt[i] <= ~flt[i];
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      en_flt <= 1'b1;
      en_cnt <= '0;
    end else if (en_flt) begin
      if (en_cnt == EW'(EN_CYC - 1)) begin
        en_flt <= 1'b0;
        en_cnt <= '0;
      end else begin
        en_cnt <= en_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsd_flt <= 1'b0;
      vcc_flt <= 1'b0;
    end else begin
      if (tsd_set)      tsd_flt <= 1'b1;
      else if (tsd_clr) tsd_flt <= 1'b0;
      if (vcc_low)       vcc_flt <= 1'b1;
      else if (vcc_high) vcc_flt <= 1'b0;
    end
  end

  assign any_flt = |flt | en_flt | tsd_flt | vcc_flt;

  always_ff @(posedge clk) begin
    if (rst || any_flt) begin
      rel     <= 1'b0;
      rel_cnt <= '0;
    end else if (!rel) begin
      if (rel_cnt == RW'(RST_CYC - 1)) begin
        rel     <= 1'b1;
        rel_cnt <= '0;
      end else begin
        rel_cnt <= rel_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ss_start) begin
      ss_lock <= 1'b1;
      ss_cnt  <= '0;
    end else if (ss_lock) begin
      if (ss_done || ss_cnt == SW'(SS_CYC - 1)) begin
        ss_lock <= 1'b0;
        ss_cnt  <= '0;
      end else begin
        ss_cnt <= ss_cnt + 1'b1;
      end
    end
  end

  assign pg          = rel & ~ss_lock & ~any_flt;
  assign ov_shutdown = flt[1];
  assign sw_pulldown = flt[1];

  assert_uv_needs_flag_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(flt[0]) |-> $past(uv_below));

  assert_ov_needs_flag_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_shutdown) |-> $past(ov_above));

  assert_release_waits_R4: assert property (@(posedge clk) disable iff (rst)
    pg |-> !$past(any_flt));

  assert_disable_drops_pg_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pg);

  assert_thermal_holds_R6: assert property (@(posedge clk) disable iff (rst)
    tsd_flt && !tsd_clr |=> tsd_flt);

  assert_vcc_holds_R7: assert property (@(posedge clk) disable iff (rst)
    vcc_flt && !vcc_high |=> vcc_flt);
endmodule

// File: tb/sim_pg_supervisor.sv
module sim_pg_supervisor;
  localparam int FILT = 3, ENC = 4, RSTC = 5, SSC = 12;

  logic clk = 0, rst = 1;
  logic en = 1, uv_below = 0, uv_above_hys = 1, ov_above = 0, ov_below_hys = 1;
  logic tsd_set = 0, tsd_clr = 1, vcc_low = 0, vcc_high = 1;
  logic ss_start = 0, ss_done = 1;
  logic pg, ov_shutdown, sw_pulldown;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pg_supervisor #(.FILT_CYC(FILT), .EN_CYC(ENC), .RST_CYC(RSTC), .SS_CYC(SSC)) u0 (
    .clk(clk), .rst(rst), .en(en), .uv_below(uv_below), .uv_above_hys(uv_above_hys),
    .ov_above(ov_above), .ov_below_hys(ov_below_hys), .tsd_set(tsd_set), .tsd_clr(tsd_clr),
    .vcc_low(vcc_low), .vcc_high(vcc_high), .ss_start(ss_start), .ss_done(ss_done),
    .pg(pg), .ov_shutdown(ov_shutdown), .sw_pulldown(sw_pulldown));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_rise(input string req, input int n);
    tick(n - 1);
    chk(req, pg, 1'b0);
    tick(1);
    chk(req, pg, 1'b1);
  endtask

  initial begin
    tick(3);
    chk("R11 pg", pg, 1'b0);
    chk("R11 ovs", ov_shutdown, 1'b0);
    chk("R11 pd", sw_pulldown, 1'b0);
    rst = 0;
    expect_rise("R5 startup", ENC + RSTC);

    for (int L = 1; L <= FILT; L++) begin
      uv_below = 1; uv_above_hys = 0;
      for (int k = 1; k <= L; k++) begin
        tick(1);
        chk("R1 R10 uv entry", pg, (k == FILT) ? 1'b0 : 1'b1);
      end
      uv_below = 0;
      if (L == FILT) begin
        uv_above_hys = 1; tick(FILT - 1);
        uv_above_hys = 0; tick(1);
        chk("R10 uv exit glitch", pg, 1'b0);
        uv_above_hys = 1;
        expect_rise("R2 R4 uv exit", FILT + RSTC);
      end else begin
        tick(1);
        chk("R10 uv gap", pg, 1'b1);
        uv_above_hys = 1;
      end
    end

    for (int L = 1; L <= FILT; L++) begin
      ov_above = 1; ov_below_hys = 0;
      tick(L);
      chk("R3 ov shutdown", ov_shutdown, L == FILT);
      chk("R3 ov pulldown", sw_pulldown, L == FILT);
      chk("R3 ov pg", pg, L != FILT);
      ov_above = 0;
      if (L == FILT) begin
        tick(2);
        chk("R3 ov held", ov_shutdown, 1'b1);
        ov_below_hys = 1;
        tick(FILT - 1);
        chk("R3 ov before clear", ov_shutdown, 1'b1);
        tick(1);
        chk("R3 ov cleared", sw_pulldown, 1'b0);
        expect_rise("R4 ov release", RSTC);
      end else begin
        ov_below_hys = 1;
        tick(1);
      end
    end

    tsd_set = 1; tsd_clr = 0; tick(1);
    chk("R6 thermal set", pg, 1'b0);
    tsd_set = 0; tick(4);
    chk("R6 thermal held", pg, 1'b0);
    tsd_clr = 1;
    expect_rise("R6 R4 thermal clear", 1 + RSTC);

    vcc_low = 1; vcc_high = 0; tick(1);
    chk("R7 vcc set", pg, 1'b0);
    vcc_low = 0; tick(3);
    chk("R7 vcc held", pg, 1'b0);
    vcc_high = 1;
    expect_rise("R7 vcc clear", 1 + RSTC);

    en = 0; tick(1);
    chk("R5 disable", pg, 1'b0);
    en = 1; tick(2);
    en = 0; tick(1);
    en = 1;
    expect_rise("R5 enable delay", ENC + RSTC);

    tsd_set = 1; tsd_clr = 0; tick(1);
    tsd_set = 0; tsd_clr = 1; tick(3);
    chk("R9 counting", pg, 1'b0);
    tsd_set = 1; tsd_clr = 0; tick(1);
    tsd_set = 0; tsd_clr = 1;
    expect_rise("R9 restart", 1 + RSTC);

    ss_done = 0; ss_start = 1; tick(1);
    chk("R8 lock", pg, 1'b0);
    ss_start = 0;
    expect_rise("R8 timeout", SSC);

    ss_start = 1; tick(1);
    ss_start = 0; tick(3);
    chk("R8 held", pg, 1'b0);
    ss_done = 1; tick(1);
    chk("R8 done no delay", pg, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule